// File: doc/BRIEF.md
# PCI Slot Interrupt Router

This block turns an interrupt request raised by a PCI device into an internal interrupt number and drives the single CPU interrupt line. A request names the device by its device/function value and by its interrupt pin (INTA..INTD as 0..3). The slot is the upper part of the device/function value. A fixed board slot table maps the slot and pin to an internal number. The onboard multi-function slot keeps its four pins apart. The display slot and the network slot each collapse to one line. The expansion slots rotate their pins so that adjacent slots share lines in a staggered pattern. Slots outside the table pass the pin number through untranslated.

Each internal number from the base 32 upward owns one bit in an edge-control mask and one bit in a polarity mask. When the edge bit is set, a request pulses the CPU line for one cycle. Otherwise the line is driven as a level equal to the polarity bit, and it holds that level until the next request that reaches the line. The mapped number is presented one cycle after each request, with a valid strobe. The enable and status registers that latch interrupts live elsewhere.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, irq_num_o is 0 and both irq_valid_o and cpu_irq_o are low.
- R2: The slot is devfn_i[7:3]. The function field devfn_i[2:0] has no effect on the mapped number.
- R3: Slot 5 maps pin p (0..3) to internal number 32 + p.
- R4: Slot 6 maps every pin to 36. Slot 7 maps every pin to 37.
- R5: Slots 8 through 12 map pin p to (slot - 8 + p) + 6 + 32. For example, slot 12 pin 3 gives 45.
- R6: Any slot outside 5..12 yields the pin number itself (0..3) as the mapped number.
- R7: For a request sampled at a clock edge, irq_num_o and irq_valid_o = 1 appear after that same edge. irq_valid_o is low after any edge without a request.
- R8: The control index is the mapped number minus 32, valid for 0..31. If edge_mask_i at that index is 1, cpu_irq_o is high for exactly one cycle after the request edge and is low after the following edge, unless another request arrives.
- R9: If edge_mask_i at the index is 0, cpu_irq_o becomes pol_mask_i at the index after the request edge and keeps that value while no request arrives.
- R10: A request whose mapped number falls outside 32..63 does not change cpu_irq_o. A level stays where it was, and a pulse that is already running still ends on time.
- R11: Mask bits at every index other than the request's own index have no effect on cpu_irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| devfn_i | input | 8 | Device/function value of the requester |
| pin_i | input | 2 | Interrupt pin index, 0..3 for INTA..INTD |
| edge_mask_i | input | 32 | Per-index pulse mode select |
| pol_mask_i | input | 32 | Per-index level value in level mode |
| irq_num_o | output | 8 | Registered mapped interrupt number |
| irq_valid_o | output | 1 | High for one cycle with each new irq_num_o |
| cpu_irq_o | output | 1 | CPU interrupt line |

## Verification
The mapping is swept over all 256 device/function values and all four pins. This separates the onboard, fixed, rotating and pass-through cases, and it shows that the function bits are ignored. Both polarity masks are alternated across the sweep, so a stale level left over from a mapped request exposes any pass-through request that wrongly touches the line. Every mapped slot and pin is then tried with a one-hot mask and with its complement. This tells a correctly indexed control bit apart from a neighbouring bit, and pulse mode apart from level mode. Back-to-back requests cover a pulse that ends while an unmapped request arrives.

// File: rtl/pci_irq_route_pkg.sv
package pci_irq_route_pkg;
  localparam int unsigned IRQ_BASE     = 32;
  localparam int unsigned SLOT_ONBOARD = 5;
  localparam int unsigned SLOT_DISPLAY = 6;
  localparam int unsigned SLOT_NETWORK = 7;
  localparam int unsigned SLOT_EXP_LO  = 8;
  localparam int unsigned SLOT_EXP_HI  = 12;
  localparam int unsigned LINE_DISPLAY = 4;
  localparam int unsigned LINE_NETWORK = 5;
  localparam int unsigned LINE_EXP_OFS = 6;

  typedef enum logic [1:0] {
    SC_ONBOARD,
    SC_FIXED,
    SC_EXPANSION,
    SC_PASS
  } slot_class_e;
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import pci_irq_route_pkg::*;
#(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned PIN_W  = 2,
  parameter int unsigned NUM_W  = 8,
  parameter int unsigned CTRL_W = 32,
  localparam int unsigned IDX_W = $clog2(CTRL_W)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [NUM_W-1:0]  num_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  slot_class_e cls;
  logic [31:0] slot_w, pin_w, num_w, rel_w;

  assign slot_w = 32'(slot_i);
  assign pin_w  = 32'(pin_i);

  always_comb begin
    if (slot_w == SLOT_ONBOARD)                              cls = SC_ONBOARD;
    else if (slot_w == SLOT_DISPLAY || slot_w == SLOT_NETWORK) cls = SC_FIXED;
    else if (slot_w >= SLOT_EXP_LO && slot_w <= SLOT_EXP_HI) cls = SC_EXPANSION;
    else                                                     cls = SC_PASS;
  end

  always_comb begin
    unique case (cls)
      SC_ONBOARD:   num_w = IRQ_BASE + (pin_w % 4);
      SC_FIXED:     num_w = IRQ_BASE + ((slot_w == SLOT_DISPLAY) ? LINE_DISPLAY : LINE_NETWORK);
      SC_EXPANSION: num_w = IRQ_BASE + LINE_EXP_OFS + (slot_w - SLOT_EXP_LO) + pin_w;
      default:      num_w = pin_w;
    endcase
  end

  assign rel_w = num_w - IRQ_BASE;
  assign num_o = NUM_W'(num_w);
  assign hit_o = (num_w >= IRQ_BASE) && (rel_w < CTRL_W);
  assign idx_o = IDX_W'(rel_w);
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl #(
  parameter int unsigned CTRL_W = 32,
  localparam int unsigned IDX_W = $clog2(CTRL_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CTRL_W-1:0] edge_mask_i,
  input  logic [CTRL_W-1:0] pol_mask_i,
  output logic              line_o
);
  logic line_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (fire_i) begin
      if (edge_mask_i[idx_i]) begin
        line_q  <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        line_q  <= pol_mask_i[idx_i];
        pulse_q <= 1'b0;
      end
    end else if (pulse_q) begin
      // pulse ends even when an unmapped request is present
      line_q  <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned PIN_W   = 2,
  parameter int unsigned NUM_W   = 8,
  parameter int unsigned CTRL_W  = 32,
  localparam int unsigned SLOT_W = DEVFN_W - 3,
  localparam int unsigned IDX_W  = $clog2(CTRL_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [DEVFN_W-1:0] devfn_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic [CTRL_W-1:0]  edge_mask_i,
  input  logic [CTRL_W-1:0]  pol_mask_i,
  output logic [NUM_W-1:0]   irq_num_o,
  output logic               irq_valid_o,
  output logic               cpu_irq_o
);
  logic [NUM_W-1:0] map_num;
  logic             map_hit;
  logic [IDX_W-1:0] map_idx;
  logic [NUM_W-1:0] num_q;
  logic             valid_q;

  irq_slot_map #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .CTRL_W(CTRL_W)
  ) u_map (
    .slot_i(devfn_i[DEVFN_W-1:3]),
    .pin_i (pin_i),
    .num_o (map_num),
    .hit_o (map_hit),
    .idx_o (map_idx)
  );

  irq_line_ctrl #(.CTRL_W(CTRL_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (req_i && map_hit),
    .idx_i      (map_idx),
    .edge_mask_i(edge_mask_i),
    .pol_mask_i (pol_mask_i),
    .line_o     (cpu_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) num_q <= map_num;
    end
  end

  assign irq_num_o   = num_q;
  assign irq_valid_o = valid_q;
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk #(
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned PIN_W   = 2,
  parameter int unsigned NUM_W   = 8,
  parameter int unsigned CTRL_W  = 32,
  localparam int unsigned IDX_W  = $clog2(CTRL_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [DEVFN_W-1:0] devfn_i,
  input logic [PIN_W-1:0]   pin_i,
  input logic [CTRL_W-1:0]  edge_mask_i,
  input logic [CTRL_W-1:0]  pol_mask_i,
  input logic [NUM_W-1:0]   irq_num_o,
  input logic               irq_valid_o,
  input logic               cpu_irq_o
);
  localparam int unsigned BASE = pci_irq_route_pkg::IRQ_BASE;

  logic [CTRL_W-1:0] em_q, pm_q;
  logic [31:0]       num_w, rel_w;
  logic              in_rng;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      em_q <= '0;
      pm_q <= '0;
    end else begin
      em_q <= edge_mask_i;
      pm_q <= pol_mask_i;
    end
  end

  assign num_w  = 32'(irq_num_o);
  assign rel_w  = num_w - BASE;
  assign in_rng = (num_w >= BASE) && (rel_w < CTRL_W);
  assign idx    = IDX_W'(rel_w);

  assert_valid_follows_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> irq_valid_o);
  assert_no_valid_without_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !irq_valid_o);
  assert_fixed_slot_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && devfn_i[DEVFN_W-1:3] == 6) |=> (num_w == BASE + 4));
  assert_pass_through_small_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !in_rng) |-> (num_w < 4));
  assert_pulse_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && in_rng && em_q[idx]) |-> cpu_irq_o);
  assert_pulse_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && in_rng && em_q[idx]) |=> (!cpu_irq_o || irq_valid_o));
  assert_level_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && in_rng && !em_q[idx]) |-> (cpu_irq_o == pm_q[idx]));
  assert_unmapped_no_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !in_rng && !$past(cpu_irq_o)) |-> !cpu_irq_o);
endmodule

bind pci_irq_router pci_irq_router_chk #(
  .DEVFN_W(DEVFN_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/pci_irq_router_tb_top.sv
`timescale 1ns/1ps
module pci_irq_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  devfn_i = '0;
  logic [1:0]  pin_i = '0;
  logic [31:0] edge_mask_i = '0;
  logic [31:0] pol_mask_i = '0;
  logic [7:0]  irq_num_o;
  logic        irq_valid_o;
  logic        cpu_irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pci_irq_router dut_i (.*);

  function automatic int exp_num(int slot, int pin);
    if (slot == 5) return 32 + pin;
    if (slot == 6) return 36;
    if (slot == 7) return 37;
    if (slot >= 8 && slot <= 12) return slot - 8 + pin + 38;
    return pin;
  endfunction

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // drive one request across one edge; returns at the next falling edge
  task automatic pulse_req(int devfn, int pin, logic [31:0] em, logic [31:0] pm);
    devfn_i = 8'(devfn); pin_i = 2'(pin);
    edge_mask_i = em; pol_mask_i = pm;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    logic exp_line;
    int n;
    @(negedge clk_i);
    check("R1 num", 32'(irq_num_o), 0);
    check("R1 valid", 32'(irq_valid_o), 0);
    check("R1 line", 32'(cpu_irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_line = 1'b0;

    // R2..R7, R9, R10: full sweep in level mode
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] pm;
        pm = ((d + p) % 2 == 1) ? 32'hFFFF_FFFF : 32'h0;
        pulse_req(d, p, 32'h0, pm);
        n = exp_num(d >> 3, p);
        if (n >= 32) exp_line = pm[0];
        check("R3 R4 R5 R6 R2 num", 32'(irq_num_o), 32'(n));
        check("R7 valid", 32'(irq_valid_o), 1);
        check("R9 R10 line", 32'(cpu_irq_o), 32'(exp_line));
        @(negedge clk_i);
        check("R7 valid low", 32'(irq_valid_o), 0);
        check("R9 level held", 32'(cpu_irq_o), 32'(exp_line));
      end
    end

    // R8, R11: each mapped slot and pin in pulse and level mode
    for (int s = 5; s <= 12; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] oh;
        n = exp_num(s, p);
        oh = 32'h1 << (n - 32);
        pulse_req(s * 8 + 3, p, oh, 32'h0);
        check("R8 pulse high", 32'(cpu_irq_o), 1);
        @(negedge clk_i);
        check("R8 pulse ends", 32'(cpu_irq_o), 0);
        pulse_req(s * 8, p, ~oh, oh);
        check("R11 level high own bit", 32'(cpu_irq_o), 1);
        pulse_req(s * 8, p, 32'h0, ~oh);
        check("R11 level low own bit", 32'(cpu_irq_o), 0);
      end
    end

    // R10: unmapped request keeps a high level
    pulse_req(6 * 8, 1, 32'h0, 32'h10);
    check("R10 setup level", 32'(cpu_irq_o), 1);
    pulse_req(20 * 8, 2, 32'hFFFF_FFFF, 32'h0);
    check("R10 level kept", 32'(irq_num_o), 2);
    check("R10 level kept line", 32'(cpu_irq_o), 1);
    pulse_req(6 * 8, 0, 32'h0, 32'h0);
    check("R9 level lowered", 32'(cpu_irq_o), 0);

    // R10: pulse ends while an unmapped request arrives back to back
    devfn_i = 8'(7 * 8); pin_i = 2'd3;
    edge_mask_i = 32'h20; pol_mask_i = 32'h0;
    req_i = 1'b1;
    @(negedge clk_i);
    check("R8 pulse start", 32'(cpu_irq_o), 1);
    devfn_i = 8'(0); pin_i = 2'd1;
    edge_mask_i = 32'hFFFF_FFFF; pol_mask_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R10 pulse ends under unmapped", 32'(cpu_irq_o), 0);
    check("R7 back to back valid", 32'(irq_valid_o), 1);
    check("R6 back to back num", 32'(irq_num_o), 1);
    @(negedge clk_i);
    check("R10 stays low", 32'(cpu_irq_o), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule